// File: doc/BRIEF.md
# Synchronous Quadrature Encoder Emulator

This block generates the three signals of an incremental shaft encoder: phase A, phase B and a once-per-revolution index. It runs entirely from one fast system clock. Two slow step sources arrive from outside without any timing relation to that clock, and a select input chooses one of them. The chosen step signal never clocks a flip-flop. It passes through a chain of synchronizing flip-flops and an edge detector. Each rising edge then becomes a one-cycle enable that moves a position counter forward by one.

The counter counts from zero up to a wrap value and then returns to zero. The wrap value comes either from a 16-bit input or from a fixed parameter, and it is never allowed below 3. Phase A, phase B and the index are decoded from the counter and then registered, so each output comes straight from a flip-flop and cannot glitch when counter bits switch with skew. The index pulse sits across the wrap point, covering the maximum count and zero while B is low.

Top module: `qenc_emulator`

## Requirements
- R1: `src_sel`=0 passes `step_src0` and `src_sel`=1 passes `step_src1`. Edges on the unselected source have no effect on the outputs.
- R2: A rising edge on the selected source reaches the outputs exactly SYNC_STAGES+2 system-clock rising edges after the input changes (4 with the default of two synchronizer stages), and never earlier.
- R3: Each rising edge of the selected source advances the position by exactly one, however long the input stays high. A falling edge never advances it.
- R4: On a step taken while the position is greater than or equal to the wrap value, the position returns to 0. Otherwise it increments by one.
- R5: With USE_MAX_PORT=1 the wrap value is `wrap_max`. With USE_MAX_PORT=0 it is the parameter DEF_MAX, which defaults to 31.
- R6: `enc_a` = NOT position bit 1, and `enc_b` = position bit 1 XOR bit 0. Successive steps therefore give (A,B) = 10, 11, 01, 00. When the wrap value has its two low bits both set, at most one of A and B changes per clock.
- R7: `enc_idx` is 1 exactly when the position equals 0 or the wrap value and `enc_b` is 0.
- R8: `enc_a`, `enc_b` and `enc_idx` are flip-flop outputs. They change only one clock after the position changes.
- R9: A synchronous active-high `rst` clears the position and the synchronizer. The clock edge after `rst` is sampled high gives `enc_a`=1, `enc_b`=0, `enc_idx`=1.
- R10: A wrap value of 0, 1 or 2 is treated as 3, so the outputs repeat with a period of 4 steps.
- R11: If the wrap value is lowered below the current position, the next step returns the position to 0.
- R12: Switching `src_sel` from a low source to a high source produces exactly one step. Switching from a high source to a low source produces none.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous active-high reset |
| step_src0 | input | 1 | Asynchronous step source chosen when `src_sel`=0 |
| step_src1 | input | 1 | Asynchronous step source chosen when `src_sel`=1 |
| src_sel | input | 1 | Step source select |
| wrap_max | input | CNT_W (16) | Programmable wrap value |
| enc_a | output | 1 | Registered phase A |
| enc_b | output | 1 | Registered phase B |
| enc_idx | output | 1 | Registered index pulse |

## Verification
A step source change is due at the outputs four clock edges later: two synchronizer edges, one counter edge and one output-register edge. One check samples just after the third edge to confirm that nothing has moved yet, and samples again after the fourth edge. All other checks hold each input level for six clocks and sample on the falling clock edge, which is well past that latency. Reset state is checked one edge after reset. The wrap sweep compares every step with a position model that the bench keeps arithmetically.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

   typedef struct packed {
      logic ph_a;
      logic ph_b;
      logic ndx;
   } qenc_out_t;

   localparam qenc_out_t QENC_HOME = '{ph_a: 1'b1, ph_b: 1'b0, ndx: 1'b1};

   function automatic qenc_out_t qenc_decode(input logic [1:0] lsb, input logic at_end);
      qenc_out_t o;
      o.ph_a = ~lsb[1];
      o.ph_b = lsb[1] ^ lsb[0];
      o.ndx  = at_end & ~o.ph_b;
      return o;
   endfunction

endpackage

// File: rtl/qenc_step_sync.sv
module qenc_step_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic step_src0,
   input  logic step_src1,
   input  logic src_sel,
   output logic step_en
);
   localparam int CHAIN_LEN = SYNC_STAGES + 1;

   logic                 raw_step;
   logic [CHAIN_LEN-1:0] chain_q;

   assign raw_step = src_sel ? step_src1 : step_src0;

   for (genvar i = 0; i < CHAIN_LEN; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (rst) chain_q[i] <= 1'b0;
            else     chain_q[i] <= raw_step;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (rst) chain_q[i] <= 1'b0;
            else     chain_q[i] <= chain_q[i-1];
         end
      end
   end

   // newest settled sample high, older sample low
   assign step_en = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];

endmodule

// File: rtl/qenc_pos_counter.sv
module qenc_pos_counter #(
   parameter int CNT_W        = 16,
   parameter int DEF_MAX      = 31,
   parameter bit USE_MAX_PORT = 1'b1,
   parameter int MIN_WRAP     = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             step_en,
   input  logic [CNT_W-1:0] max_in,
   output logic [CNT_W-1:0] pos,
   output logic [CNT_W-1:0] wrap_eff
);
   localparam logic [CNT_W-1:0] MIN_V = CNT_W'(MIN_WRAP);
   localparam logic [CNT_W-1:0] DEF_V = CNT_W'(DEF_MAX);
   localparam logic [CNT_W-1:0] ONE_V = CNT_W'(1);

   logic [CNT_W-1:0] wrap_raw;

   if (USE_MAX_PORT) begin : g_port_wrap
      assign wrap_raw = max_in;
   end else begin : g_fixed_wrap
      logic unused_max;
      assign unused_max = ^max_in;
      assign wrap_raw   = DEF_V;
   end

   assign wrap_eff = (wrap_raw < MIN_V) ? MIN_V : wrap_raw;

   always_ff @(posedge clk) begin
      if (rst) begin
         pos <= '0;
      end else if (step_en) begin
         if (pos >= wrap_eff) pos <= '0;
         else                 pos <= pos + ONE_V;
      end
   end

endmodule

// File: rtl/qenc_out_decode.sv
module qenc_out_decode
   import qenc_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [CNT_W-1:0] pos,
   input  logic [CNT_W-1:0] wrap_eff,
   output logic             enc_a,
   output logic             enc_b,
   output logic             enc_idx
);
   logic      at_end;
   qenc_out_t out_q;

   assign at_end = (pos == '0) || (pos == wrap_eff);

   always_ff @(posedge clk) begin
      if (rst) out_q <= QENC_HOME;
      else     out_q <= qenc_decode(pos[1:0], at_end);
   end

   assign enc_a   = out_q.ph_a;
   assign enc_b   = out_q.ph_b;
   assign enc_idx = out_q.ndx;

endmodule

// File: rtl/qenc_emulator.sv
module qenc_emulator #(
   parameter int CNT_W        = 16,
   parameter int DEF_MAX      = 31,
   parameter bit USE_MAX_PORT = 1'b1,
   parameter int SYNC_STAGES  = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             step_src0,
   input  logic             step_src1,
   input  logic             src_sel,
   input  logic [CNT_W-1:0] wrap_max,
   output logic             enc_a,
   output logic             enc_b,
   output logic             enc_idx
);
   if (CNT_W < 2) begin : g_bad_width
      $error("qenc_emulator: CNT_W must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("qenc_emulator: SYNC_STAGES must be at least 2");
   end
   if (CNT_W < 31 && DEF_MAX >= (1 << CNT_W)) begin : g_bad_def
      $error("qenc_emulator: DEF_MAX does not fit in CNT_W bits");
   end

   logic             step_en;
   logic [CNT_W-1:0] pos;
   logic [CNT_W-1:0] wrap_eff;

   qenc_step_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst), .step_src0(step_src0), .step_src1(step_src1),
      .src_sel(src_sel), .step_en(step_en)
   );

   qenc_pos_counter #(
      .CNT_W(CNT_W), .DEF_MAX(DEF_MAX), .USE_MAX_PORT(USE_MAX_PORT), .MIN_WRAP(3)
   ) u_cnt (
      .clk(clk), .rst(rst), .step_en(step_en), .max_in(wrap_max),
      .pos(pos), .wrap_eff(wrap_eff)
   );

   qenc_out_decode #(.CNT_W(CNT_W)) u_dec (
      .clk(clk), .rst(rst), .pos(pos), .wrap_eff(wrap_eff),
      .enc_a(enc_a), .enc_b(enc_b), .enc_idx(enc_idx)
   );

endmodule

// File: rtl/qenc_emulator_chk.sv
module qenc_emulator_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst,
   input logic             step_en,
   input logic [CNT_W-1:0] pos,
   input logic [CNT_W-1:0] wrap_eff,
   input logic             enc_a,
   input logic             enc_b,
   input logic             enc_idx
);
   // R3: an enable lasts one cycle only
   a_r3_single_cycle_en: assert property (@(posedge clk) disable iff (rst)
      step_en |=> !step_en);

   // R4: position holds without an enable
   a_r4_hold_without_en: assert property (@(posedge clk) disable iff (rst)
      !step_en |=> $stable(pos));

   // R4 / R11: a step at or beyond the wrap value returns to zero
   a_r4_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
      (step_en && (pos >= wrap_eff)) |=> (pos == '0));

   // R10: the effective wrap value is never below 3
   a_r10_wrap_clamped: assert property (@(posedge clk) disable iff (rst)
      wrap_eff >= CNT_W'(3));

   // R6: only one phase changes per clock for a wrap value ending in binary 11
   a_r6_gray_phase: assert property (@(posedge clk) disable iff (rst)
      ((wrap_eff[1:0] == 2'b11) && $stable(wrap_eff) && (pos <= wrap_eff))
      |=> ##1 ($countones({enc_a, enc_b} ^ $past({enc_a, enc_b})) <= 1));

   // R7: index never high while B is high
   a_r7_idx_b_low: assert property (@(posedge clk) disable iff (rst)
      enc_idx |-> !enc_b);

   // R9: reset puts outputs at the home state
   a_r9_reset_home: assert property (@(posedge clk)
      rst |=> (enc_a && !enc_b && enc_idx));

endmodule

bind qenc_emulator qenc_emulator_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst(rst), .step_en(step_en), .pos(pos), .wrap_eff(wrap_eff),
   .enc_a(enc_a), .enc_b(enc_b), .enc_idx(enc_idx)
);

// File: tb/qenc_emulator_tb.sv
module qenc_emulator_tb;
   localparam int CLK_P = 10;
   localparam int CW    = 16;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          step_src0 = 1'b0;
   logic          step_src1 = 1'b0;
   logic          src_sel = 1'b0;
   logic [CW-1:0] wrap_max = CW'(31);
   logic          enc_a, enc_b, enc_idx;

   int checks = 0;
   int failures = 0;
   int model_pos = 0;
   bit done = 1'b0;

   always #(CLK_P/2) clk = ~clk;

   qenc_emulator #(.CNT_W(CW), .DEF_MAX(31), .USE_MAX_PORT(1'b1), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst(rst), .step_src0(step_src0), .step_src1(step_src1),
      .src_sel(src_sel), .wrap_max(wrap_max),
      .enc_a(enc_a), .enc_b(enc_b), .enc_idx(enc_idx)
   );

   function automatic int eff_wrap();
      int w = int'(wrap_max);
      return (w < 3) ? 3 : w;
   endfunction

   function automatic logic [2:0] expect_out(int p);
      logic a, b, x;
      a = ~p[1];
      b = p[1] ^ p[0];
      x = ((p == 0) || (p == eff_wrap())) && !b;
      return {a, b, x};
   endfunction

   task automatic model_step();
      if (model_pos >= eff_wrap()) model_pos = 0;
      else                         model_pos = model_pos + 1;
   endtask

   task automatic check(string req, logic [2:0] expv);
      checks++;
      if ({enc_a, enc_b, enc_idx} !== expv) begin
         failures++;
         $display("FAIL %s: {a,b,idx} actual=%b expected=%b (model pos %0d)",
                  req, {enc_a, enc_b, enc_idx}, expv, model_pos);
      end
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      idle(3);
      rst = 1'b0;
      model_pos = 0;
   endtask

   // rising then falling edge on the selected source
   task automatic pulse(bit which);
      @(negedge clk);
      if (which) step_src1 = 1'b1; else step_src0 = 1'b1;
      idle(6);
      if (which) step_src1 = 1'b0; else step_src0 = 1'b0;
      idle(6);
   endtask

   initial begin
      do_reset();
      idle(1);
      check("R9 reset home", 3'b101);

      // R2: exact latency of SYNC_STAGES+2 edges
      @(negedge clk);
      step_src0 = 1'b1;
      repeat (3) @(posedge clk);
      #1 check("R2 no change before 4th edge", expect_out(model_pos));
      @(posedge clk);
      model_step();
      #1 check("R2 change after 4th edge", expect_out(model_pos));
      // R8: registered output trails the position by one clock (part of the 4)
      idle(20);
      check("R3 held high gives one step", expect_out(model_pos));
      step_src0 = 1'b0;
      idle(20);
      check("R3 falling edge gives no step", expect_out(model_pos));

      // R1: select 1, pulses on source 0 ignored, source 1 counted
      src_sel = 1'b1;
      idle(4);
      pulse(1'b0);
      pulse(1'b0);
      check("R1 unselected source ignored", expect_out(model_pos));
      pulse(1'b1);
      model_step();
      check("R1 source 1 selected", expect_out(model_pos));
      src_sel = 1'b0;
      idle(4);
      pulse(1'b1);
      check("R1 source 1 ignored when sel=0", expect_out(model_pos));

      // R12: select switching creates at most one edge
      @(negedge clk);
      step_src1 = 1'b1;
      idle(6);
      src_sel = 1'b1;
      idle(8);
      model_step();
      check("R12 low-to-high switch gives one step", expect_out(model_pos));
      src_sel = 1'b0;
      idle(8);
      check("R12 high-to-low switch gives no step", expect_out(model_pos));
      step_src1 = 1'b0;
      idle(6);

      // R4/R5/R6/R7/R10: sweep of wrap values, two full periods each
      foreach (sweep_vals[k]) begin
         wrap_max = CW'(sweep_vals[k]);
         do_reset();
         idle(1);
         check("R9 reset home in sweep", 3'b101);
         for (int s = 0; s < 2 * (eff_wrap() + 1) + 2; s++) begin
            pulse(1'b0);
            model_step();
            if (sweep_vals[k] < 3)
               check("R10 clamped wrap sequence", expect_out(model_pos));
            else if (model_pos == 0)
               check("R4 wrap to zero / R7 index", expect_out(model_pos));
            else
               check("R6 phase decode / R7 index / R5 wrap port", expect_out(model_pos));
         end
      end

      // R11: lower wrap below current position
      wrap_max = CW'(31);
      do_reset();
      for (int s = 0; s < 20; s++) begin
         pulse(1'b0);
         model_step();
      end
      check("R5 position 20 with wrap 31", expect_out(model_pos));
      wrap_max = CW'(5);
      idle(2);
      pulse(1'b0);
      model_step();
      check("R11 lowered wrap returns to zero", expect_out(model_pos));
      if (model_pos != 0) begin
         failures++;
         $display("FAIL R11: model position %0d expected 0", model_pos);
      end

      // R9: reset mid-count
      pulse(1'b0);
      model_step();
      do_reset();
      idle(1);
      check("R9 reset mid-count", 3'b101);

      if (!done) begin
         done = 1'b1;
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   int sweep_vals [9] = '{0, 1, 2, 3, 4, 5, 6, 7, 31};

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         failures++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule